// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is a clocked I2C target that behaves like a byte-addressed serial EEPROM. The system clock oversamples SCL and SDA through a short synchroniser. The block finds START, repeated START and STOP conditions and compares the 7-bit device identifier. It drives SDA open-drain: when `sda_oe` is high, the pad pulls the line low. A master sends a device header, then a 16-bit word address with the high byte first, and then either data bytes to write or a repeated START to read.

Incoming write data collects in a page buffer. Inside a page, only the low address bits advance, so data loaded past the end of a page wraps to the start of the same page. The STOP that closes a write carrying data starts a timed internal write cycle. The buffered bytes are copied into the array while that cycle runs. For the whole cycle, the block refuses its own device header, which lets a master poll for completion.

A persistent address counter supports three kinds of read:
- a read from the current counter position;
- a random read, which reloads the counter through a write header that carries no data;
- a sequential read, which runs past the top of memory and wraps to zero.

A protect input is captured at one fixed point before the first data byte. When it is high, the write is refused.

Top module: `eep_i2c_target`

## Requirements
- R1: The block answers only a header whose upper 7 bits equal `DEV_ID` (default 7'h50, so 8'hA0 writes and 8'hA1 reads). It pulls SDA low in the ninth clock of a matching header. For any other identifier it leaves SDA released and ignores the bus until the next START or STOP.
- R2: After a write header, the block acknowledges two address bytes, high byte first. These bytes form the word address. The counter keeps the low `MEM_AW` bits of it.
- R3: Word address bits above bit 6 select the page, and bits 6..0 select the byte inside a 128-byte page. After each data byte is accepted, only bits 6..0 increment. So byte 129 of one transaction lands on the location of byte 1, and the next page stays unchanged.
- R4: Only a STOP that ends a write carrying at least one accepted data byte starts the internal write cycle. A STOP after the address bytes alone changes no location, and the next header is acknowledged at once.
- R5: For `WR_CYCLES` clocks after the launching STOP, the block acknowledges no header, neither read nor write. After that time it acknowledges again and the new data reads back.
- R6: The protect input is captured on the SCL falling edge that ends the acknowledge of the low address byte. If it was high there, the first data byte is not acknowledged, nothing is written and no write cycle starts. A change of the input after that edge has no effect on the transaction.
- R7: After reset, SDA is released and every location reads 8'hFF.
- R8: A read header (bit 0 = 1) is acknowledged. The block then shifts out, MSB first, the byte at the address counter.
- R9: The counter always points one past the last byte read or written, and it rolls from the top address to 0.
- R10: A write header with two address bytes, followed by a repeated START and a read header, makes the read begin at that word address.
- R11: During a read, each master acknowledge makes the block send the following byte, wrapping at the end of memory. A master non-acknowledge ends the transfer, and SDA stays released until STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus (resolved wired-AND level) |
| prot_i | input | 1 | Write protect, active high |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
- **Write patterns.** The bench writes single bytes at three separate addresses and then a 130-byte page burst. Read-back of the burst shows whether the address wraps inside the page or spills into the next page.
- **Reads of the counter.** A header-only write, a random read, a current-address read and an acknowledged sequential read across the top address together separate a counter that is loaded, one that advances, and one that rolls over.
- **Polling.** Headers sent right after a STOP and again after the timer expires show whether the write cycle started, and whether it started only when data was present.
- **Protection.** The protect input is held high through the capture edge in one transaction and raised only after that edge in another. The first must be refused and the second must be accepted.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_WR,
        PH_RD
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
        logic prot;
    } bus_ev_t;

    function automatic logic dev_match(input logic [6:0] hdr_id, input logic [6:0] own_id);
        return hdr_id == own_id;
    endfunction

endpackage

// File: rtl/eep_bus_sampler.sv
module eep_bus_sampler
    import eep_pkg::*;
#(
    parameter int SYNC_STAGES = 2
)(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    input  logic    prot_i,
    output bus_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_s, sda_s, prot_s;
    logic scl_q, sda_q;
    logic scl_n, sda_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_s  <= '1;
            sda_s  <= '1;
            prot_s <= '0;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_s  <= {scl_s[SYNC_STAGES-2:0], scl_i};
            sda_s  <= {sda_s[SYNC_STAGES-2:0], sda_i};
            prot_s <= {prot_s[SYNC_STAGES-2:0], prot_i};
            scl_q  <= scl_s[SYNC_STAGES-1];
            sda_q  <= sda_s[SYNC_STAGES-1];
        end
    end

    always_comb begin
        scl_n    = scl_s[SYNC_STAGES-1];
        sda_n    = sda_s[SYNC_STAGES-1];
        ev.rise  = scl_n & ~scl_q;
        ev.fall  = ~scl_n & scl_q;
        ev.start = scl_n & scl_q & sda_q & ~sda_n;
        ev.stop  = scl_n & scl_q & ~sda_q & sda_n;
        ev.sda   = sda_n;
        ev.prot  = prot_s[SYNC_STAGES-1];
    end

endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int PAGE_AW = 7
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [PAGE_AW-1:0] wr_idx,
    input  logic [7:0]         wr_data,
    input  logic               clear,
    input  logic               launch,
    output logic               cm_we,
    output logic [PAGE_AW-1:0] cm_idx,
    output logic [7:0]         cm_data
);
    localparam int PAGE_BYTES = 1 << PAGE_AW;

    logic [7:0]            slot [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid;
    logic [PAGE_AW-1:0]    idx;
    logic                  active;

    always_ff @(posedge clk) begin
        if (wr_en) slot[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= '0;
            idx    <= '0;
            active <= 1'b0;
        end else begin
            if (clear) valid <= '0;
            if (wr_en) valid[wr_idx] <= 1'b1;
            if (launch) begin
                active <= 1'b1;
                idx    <= '0;
            end else if (active) begin
                valid[idx] <= 1'b0;
                idx        <= idx + 1'b1;
                if (idx == '1) active <= 1'b0;
            end
        end
    end

    assign cm_we   = active & valid[idx];
    assign cm_idx  = idx;
    assign cm_data = slot[idx];

    // The page buffer must never be filled while it is being drained (R5)
    assert_fill_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !active);

    // A new write cycle may only launch from an idle sequencer (R4)
    assert_launch_idle_R4: assert property (@(posedge clk) disable iff (rst)
        launch |-> !active);

endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int MEM_AW = 9
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [MEM_AW-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [MEM_AW-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/eep_i2c_target.sv
module eep_i2c_target
    import eep_pkg::*;
#(
    parameter logic [6:0] DEV_ID      = 7'h50,
    parameter int         MEM_AW      = 9,
    parameter int         PAGE_AW     = 7,
    parameter int         WR_CYCLES   = 1000,
    parameter int         SYNC_STAGES = 2
)(
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic prot_i,
    output logic sda_oe
);
    localparam int PAGE_BYTES = 1 << PAGE_AW;
    localparam int WR_LEN     = (WR_CYCLES > PAGE_BYTES) ? WR_CYCLES : PAGE_BYTES + 1;
    localparam int TMR_W      = $clog2(WR_LEN + 1);
    localparam int PG_W       = MEM_AW - PAGE_AW;

    bus_ev_t             ev;
    phase_e              state;
    logic [3:0]          cnt;
    logic [7:0]          shreg, tx, addr_hi, rdata;
    logic                rw, mack, wp_lat, first, have_data;
    logic [MEM_AW-1:0]   ctr;
    logic [TMR_W-1:0]    tmr;
    logic                busy;
    logic [PG_W-1:0]     cm_page;
    logic                cm_we;
    logic [PAGE_AW-1:0]  cm_idx;
    logic [7:0]          cm_data;
    logic                byte_end, ack_end, data_take, wr_launch, buf_clear;

    eep_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .prot_i(prot_i), .ev(ev)
    );

    always_comb begin
        busy      = (tmr != '0);
        byte_end  = ev.fall && (cnt == 4'd8) && (state != PH_IDLE);
        ack_end   = ev.fall && (cnt == 4'd9) && (state != PH_IDLE);
        data_take = byte_end && (state == PH_WR) && !(first && wp_lat);
        wr_launch = ev.stop && have_data;
        buf_clear = ev.start && have_data;
    end

    eep_page_buf #(.PAGE_AW(PAGE_AW)) u_page_buf (
        .clk(clk), .rst(rst),
        .wr_en(data_take), .wr_idx(ctr[PAGE_AW-1:0]), .wr_data(shreg),
        .clear(buf_clear), .launch(wr_launch),
        .cm_we(cm_we), .cm_idx(cm_idx), .cm_data(cm_data)
    );

    eep_array #(.MEM_AW(MEM_AW)) u_array (
        .clk(clk), .rst(rst),
        .we(cm_we), .waddr({cm_page, cm_idx}), .wdata(cm_data),
        .raddr(ctr), .rdata(rdata)
    );

    // internal write-cycle timer
    always_ff @(posedge clk) begin
        if (rst)            tmr <= '0;
        else if (wr_launch) tmr <= TMR_W'(WR_LEN);
        else if (busy)      tmr <= tmr - 1'b1;
    end

    // protocol engine
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PH_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            tx        <= '0;
            addr_hi   <= '0;
            rw        <= 1'b0;
            mack      <= 1'b1;
            wp_lat    <= 1'b0;
            first     <= 1'b0;
            have_data <= 1'b0;
            ctr       <= '0;
            sda_oe    <= 1'b0;
            cm_page   <= '0;
        end else begin
            if (wr_launch) begin
                have_data <= 1'b0;
                cm_page   <= ctr[MEM_AW-1:PAGE_AW];
            end
            if (ev.start) begin
                state     <= PH_DEV;
                cnt       <= '0;
                sda_oe    <= 1'b0;
                have_data <= 1'b0;
            end else if (ev.stop) begin
                state  <= PH_IDLE;
                sda_oe <= 1'b0;
            end else if (state != PH_IDLE) begin
                if (ev.rise) begin
                    if (cnt < 4'd8) shreg <= {shreg[6:0], ev.sda};
                    if (cnt == 4'd8 && state == PH_RD) mack <= ev.sda;
                    cnt <= cnt + 1'b1;
                end else if (byte_end) begin
                    case (state)
                        PH_DEV: begin
                            if (dev_match(shreg[7:1], DEV_ID) && !busy) begin
                                sda_oe <= 1'b1;
                                rw     <= shreg[0];
                            end else begin
                                state <= PH_IDLE;
                            end
                        end
                        PH_AHI: begin
                            addr_hi <= shreg;
                            sda_oe  <= 1'b1;
                        end
                        PH_ALO: begin
                            ctr    <= MEM_AW'({addr_hi, shreg});
                            sda_oe <= 1'b1;
                        end
                        PH_WR: begin
                            if (data_take) begin
                                ctr       <= {ctr[MEM_AW-1:PAGE_AW], ctr[PAGE_AW-1:0] + 1'b1};
                                have_data <= 1'b1;
                                first     <= 1'b0;
                                sda_oe    <= 1'b1;
                            end else begin
                                state <= PH_IDLE;
                            end
                        end
                        PH_RD:   sda_oe <= 1'b0;
                        default: ;
                    endcase
                end else if (ack_end) begin
                    cnt <= '0;
                    case (state)
                        PH_DEV: begin
                            if (rw) begin
                                state  <= PH_RD;
                                tx     <= rdata;
                                sda_oe <= ~rdata[7];
                                ctr    <= ctr + 1'b1;
                            end else begin
                                state  <= PH_AHI;
                                sda_oe <= 1'b0;
                            end
                        end
                        PH_AHI: begin
                            state  <= PH_ALO;
                            sda_oe <= 1'b0;
                        end
                        PH_ALO: begin
                            state  <= PH_WR;
                            sda_oe <= 1'b0;
                            wp_lat <= ev.prot;
                            first  <= 1'b1;
                        end
                        PH_WR:   sda_oe <= 1'b0;
                        PH_RD: begin
                            if (!mack) begin
                                tx     <= rdata;
                                sda_oe <= ~rdata[7];
                                ctr    <= ctr + 1'b1;
                            end else begin
                                state  <= PH_IDLE;
                                sda_oe <= 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end else if (ev.fall && state == PH_RD && cnt != 4'd0 && cnt < 4'd8) begin
                    sda_oe <= ~tx[3'd7 - cnt[2:0]];
                end
            end
        end
    end

    // Header during the write cycle is never acknowledged (R5)
    assert_busy_silent_R5: assert property (@(posedge clk) disable iff (rst)
        (byte_end && state == PH_DEV && busy) |=> !sda_oe);

    // Accepting data never changes the page bits of the counter (R3)
    assert_page_hold_R3: assert property (@(posedge clk) disable iff (rst)
        data_take |=> ctr[MEM_AW-1:PAGE_AW] == $past(ctr[MEM_AW-1:PAGE_AW]));

    // Protected first byte is refused and the transfer abandoned (R6)
    assert_wp_reject_R6: assert property (@(posedge clk) disable iff (rst)
        (byte_end && state == PH_WR && first && wp_lat) |=> (!sda_oe && state == PH_IDLE));

    // A STOP without buffered data leaves the timer idle (R4)
    assert_no_empty_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && !have_data && !busy) |=> !busy);

    // Reading the top address rolls the counter to zero (R9)
    assert_rd_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (ack_end && state == PH_RD && !mack && ctr == '1) |=> ctr == '0);

endmodule

// File: tb/test_eep_i2c_target.sv
module test_eep_i2c_target;

    localparam int WRC = 1000;
    localparam int Q   = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic prot = 1'b0;
    logic oe;
    logic sda_line;

    always #5 clk = ~clk;

    assign sda_line = ~(m_low | oe);

    eep_i2c_target #(.WR_CYCLES(WRC)) i_eep_i2c_target (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
        .prot_i(prot), .sda_oe(oe)
    );

    // scoreboard
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] act_v;
    logic       act_stb = 1'b0;
    int         n_vec = 0;
    int         n_bad = 0;
    logic       done = 1'b0;

    task automatic expect_v(input string t, input logic [7:0] v);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic observe(input logic [7:0] v);
        act_v   = v;
        act_stb = 1'b1;
        #1;
        act_stb = 1'b0;
        #1;
    endtask

    always @(posedge act_stb) begin : monitor
        logic [7:0] e;
        string t;
        n_vec++;
        if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL unqueued result: actual %02h expected none", act_v);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (act_v !== e) begin
                n_bad++;
                $display("FAIL %s: actual %02h expected %02h", t, act_v, e);
            end
        end
    end

    // bus master
    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; hold();
        m_scl = 1'b1; hold();
        m_low = 1'b1; hold();
        m_scl = 1'b0; hold();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; hold();
        m_scl = 1'b1; hold();
        m_low = 1'b0; hold();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; hold();
            m_scl = 1'b1;  hold();
            m_scl = 1'b0;  hold();
        end
        m_low = 1'b0; hold();
        m_scl = 1'b1; repeat (Q/2) @(negedge clk);
        ack = sda_line; repeat (Q/2) @(negedge clk);
        m_scl = 1'b0; hold();
    endtask

    task automatic get_byte(input logic nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_low = 1'b0; hold();
            m_scl = 1'b1; repeat (Q/2) @(negedge clk);
            b[i] = sda_line; repeat (Q/2) @(negedge clk);
            m_scl = 1'b0; hold();
        end
        m_low = ~nack; hold();
        m_scl = 1'b1;  hold();
        m_scl = 1'b0;  hold();
        m_low = 1'b0;
    endtask

    task automatic tx(input string t, input logic [7:0] b, input logic exp_ack);
        logic a;
        expect_v(t, {7'd0, exp_ack});
        put_byte(b, a);
        observe({7'd0, a});
    endtask

    task automatic rx(input string t, input logic [7:0] exp, input logic nack);
        logic [7:0] b;
        expect_v(t, exp);
        get_byte(nack, b);
        observe(b);
    endtask

    task automatic wait_cycle();
        repeat (WRC + 200) @(negedge clk);
    endtask

    task automatic set_addr(input string t, input logic [15:0] a);
        bus_start();
        tx(t, 8'hA0, 1'b0);
        tx(t, a[15:8], 1'b0);
        tx(t, a[7:0], 1'b0);
    endtask

    task automatic byte_write(input logic [15:0] a, input logic [7:0] d);
        set_addr("R2", a);
        tx("R2", d, 1'b0);
        bus_stop();
        wait_cycle();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R7: released after reset
        expect_v("R7", 8'h00);
        observe({7'd0, oe});

        // R8 / R7: current-address read of location 0 after reset
        bus_start();
        tx("R8", 8'hA1, 1'b0);
        rx("R7", 8'hFF, 1'b1);
        bus_stop();

        // R1: foreign identifier ignored, own identifier answered
        bus_start();
        tx("R1", 8'h46, 1'b1);
        bus_stop();
        bus_start();
        tx("R1", 8'hA0, 1'b0);
        bus_stop();

        // R5: polling during the write cycle
        set_addr("R2", 16'h0005);
        tx("R2", 8'hA5, 1'b0);
        bus_stop();
        bus_start();
        tx("R5", 8'hA0, 1'b1);
        bus_stop();
        bus_start();
        tx("R5", 8'hA1, 1'b1);
        bus_stop();
        wait_cycle();
        bus_start();
        tx("R5", 8'hA0, 1'b0);
        bus_stop();

        byte_write(16'h01FF, 8'hC3);
        byte_write(16'h0000, 8'h3C);

        // R10: random read, then R9 current read follows on
        set_addr("R10", 16'h0005);
        bus_start();
        tx("R10", 8'hA1, 1'b0);
        rx("R10", 8'hA5, 1'b1);
        bus_stop();
        bus_start();
        tx("R9", 8'hA1, 1'b0);
        rx("R9", 8'hFF, 1'b1);
        bus_stop();

        // R4: header-only write starts no cycle; R11 sequential read wraps
        set_addr("R4", 16'h01FE);
        bus_stop();
        bus_start();
        tx("R4", 8'hA1, 1'b0);
        rx("R11", 8'hFF, 1'b0);
        rx("R11", 8'hC3, 1'b0);
        rx("R9", 8'h3C, 1'b0);
        rx("R11", 8'hFF, 1'b1);
        bus_stop();

        // R3: 130-byte burst into page at 0x0100
        set_addr("R3", 16'h0100);
        for (int i = 0; i < 130; i++) tx("R3", 8'(i + 16), 1'b0);
        bus_stop();
        wait_cycle();
        bus_start();
        tx("R9", 8'hA1, 1'b0);
        rx("R9", 8'h12, 1'b1);
        bus_stop();
        set_addr("R3", 16'h0100);
        bus_start();
        tx("R3", 8'hA1, 1'b0);
        rx("R3", 8'h90, 1'b0);
        rx("R3", 8'h91, 1'b0);
        rx("R3", 8'h12, 1'b1);
        bus_stop();
        set_addr("R3", 16'h017E);
        bus_start();
        tx("R3", 8'hA1, 1'b0);
        rx("R3", 8'h8E, 1'b0);
        rx("R3", 8'h8F, 1'b0);
        rx("R3", 8'hFF, 1'b1);
        bus_stop();

        // R6: protected write refused
        prot = 1'b1;
        set_addr("R6", 16'h0010);
        tx("R6", 8'h77, 1'b1);
        bus_stop();
        prot = 1'b0;
        bus_start();
        tx("R6", 8'hA0, 1'b0);
        bus_stop();
        set_addr("R6", 16'h0010);
        bus_start();
        tx("R6", 8'hA1, 1'b0);
        rx("R6", 8'hFF, 1'b1);
        bus_stop();

        // R6: protect raised after the capture edge has no effect
        set_addr("R6", 16'h0011);
        repeat (20) @(negedge clk);
        prot = 1'b1;
        tx("R6", 8'h55, 1'b0);
        bus_stop();
        prot = 1'b0;
        wait_cycle();
        set_addr("R6", 16'h0011);
        bus_start();
        tx("R6", 8'hA1, 1'b0);
        rx("R6", 8'h55, 1'b1);
        bus_stop();

        repeat (10) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule